// File: doc/BRIEF.md
# Serial SAR Converter Host Sequencer

This block sits on the host side of a 12-bit, two-input successive-approximation converter that is reached over four wires. Those wires are a start strobe, a serial clock, a serial data line toward the converter and a serial data line back from it. A single request pulse on the user side sets off a full sequence. The block raises the start strobe and holds it for the worst-case conversion time, then lowers it. It then runs twelve serial clock pulses. During those pulses it sends a 6-bit setup word and collects the 12-bit code. Before it accepts the next request it waits until the acquisition, tail and total-cycle limits are all met. Every time limit is given in nanoseconds and converted to a count of system clock cycles, rounded up.

The converter applies a setup word to the conversion that follows the readout in which the word was sent, not to the current one. The block therefore keeps the setup word it sent last. Each result is labelled with the setup that actually produced it: single-ended or differential, the odd/sign selector, and unipolar or bipolar. The selector pair works as follows. In differential mode, 0 makes input 0 positive and 1 makes input 1 positive. In single-ended mode, 0 picks input 0 and 1 picks input 1, both measured against ground. A unipolar result is widened with zeros. A bipolar result is widened by copying its top bit. The first result after reset carries the converter's power-on setup and a flag that says so.

Top module: `sarh_ctrl`

## Requirements
- R1: A request is taken only when the block is idle. A request made while busy changes nothing: it causes no extra rising edge on the start strobe and it does not alter the setup word sent in the next readout.
- R2: The start strobe stays high for at least the conversion time (1600 ns by default), which also covers its 20 ns minimum high time, before it is lowered.
- R3: The setup word goes out on the first 6 serial clock rising edges after the strobe falls, most significant bit first. Bit 5 is single-ended (1) or differential (0), bit 4 is the odd/sign selector, bit 1 is unipolar (1) or bipolar (0), and bits 3, 2 and 0 are 0.
- R4: Each readout has exactly 12 serial clock pulses. The serial clock rests low and is high only while the strobe is low. The result is built most significant bit first from the return line, sampled at each rising edge. The top bit is already present when the strobe falls.
- R5: The serial clock high and low phases each last at least SCK_PHASE_NS (13 ns by default). This keeps each phase at or above 10 ns and the period at or above 25 ns.
- R6: Between two rising edges of the start strobe there are at least CYCLE_NS (2000 ns). At least 240 ns pass from the 7th serial clock rise to the next start, and at least 20 ns pass from the last serial clock fall to the next start.
- R7: Each result is labelled with the setup word sent in the readout before the conversion that produced it. The labels are res_single, res_odd and res_uni.
- R8: res_data is 16 bits. When the label is unipolar, bits 15:12 are zero. When it is bipolar, bits 15:12 copy bit 11.
- R9: The first result after reset carries the power-on setup (differential, selector 0, bipolar) with res_first set. Every later result has res_first clear.
- R10: During and right after reset, the start strobe, serial clock, busy and res_valid are all low.
- R11: busy is high from the cycle after a request is accepted until the cycle limits are met. res_valid is a one-cycle pulse, given once per conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request a conversion (taken when idle) |
| req_single | input | 1 | Requested mode: 1 single-ended, 0 differential |
| req_odd | input | 1 | Requested odd/sign selector |
| req_uni | input | 1 | Requested format: 1 unipolar, 0 bipolar |
| busy | output | 1 | Sequence in progress |
| adc_cnv | output | 1 | Conversion start strobe |
| adc_sck | output | 1 | Serial clock |
| adc_sdi | output | 1 | Setup word toward the converter |
| adc_sdo | input | 1 | Result bits from the converter |
| res_valid | output | 1 | One-cycle result strobe |
| res_data | output | 16 | Widened result |
| res_single | output | 1 | Label: single-ended bit of the producing setup |
| res_odd | output | 1 | Label: selector bit of the producing setup |
| res_uni | output | 1 | Label: unipolar bit of the producing setup |
| res_first | output | 1 | Result used the power-on setup |

## Verification
Some rules are checked by the assertions on every cycle. The strobe may only rise from idle, and only after the cycle and acquisition counts have run out. It may fall only after the conversion count. The serial clock is never high while the strobe is high. The outgoing bit holds steady through each clock high phase. The upper result bits must agree with the unipolar label, and the first-result flag may never come back once cleared.

Other behaviour needs the bench's converter model, which times every edge in nanoseconds. The model checks the pipelined labelling: each result must carry the setup latched one readout earlier. It checks the order of the setup bits, the exact count of 12 clock pulses and the true phase widths. It also checks that a request made while busy leaves no trace on the wires.

// File: rtl/sarh_pkg.sv
`timescale 1ns/1ps
// Package: shared setup type, sequencer states and the setup-word layout.
// Assumes a 6-bit setup word with the converter latching it MSB first.
package sarh_pkg;

    typedef struct packed {
        logic single;
        logic odd;
        logic uni;
    } sarh_cfg_t;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_CONV   = 2'd1,
        ST_READ   = 2'd2,
        ST_SETTLE = 2'd3
    } sarh_state_t;

    localparam int WORD_W = 6;

    // Place the setup fields at the bit positions the converter decodes.
    function automatic logic [WORD_W-1:0] cfg_word(input sarh_cfg_t c);
        return {c.single, c.odd, 2'b00, c.uni, 1'b0};
    endfunction

endpackage

// File: rtl/sarh_link.sv
`timescale 1ns/1ps
// Module: serial engine. Once started it runs NBITS clock pulses, each
// phase HALF system cycles long. It sends the setup word MSB first (the
// bit changes while the clock is low) and samples the return line at
// each rising edge. The clock rests low.
// Assumes: start arrives only while idle, and the return line changes
// only on falling edges of the serial clock.
module sarh_link #(
    parameter int NBITS     = 12,
    parameter int WORD_W    = 6,
    parameter int HALF      = 2,
    parameter int ACQ_RISE  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [WORD_W-1:0] word,
    input  logic              sdo,
    output logic              sck,
    output logic              sdi,
    output logic              acq_mark,
    output logic              done,
    output logic [NBITS-1:0]  data
);
    localparam int PW = (HALF > 1) ? $clog2(HALF) : 1;
    localparam int NW = $clog2(NBITS + 1);
    localparam logic [PW-1:0] PH_END  = PW'(HALF - 1);
    localparam logic [NW-1:0] NB_LAST = NW'(NBITS - 1);
    localparam logic [NW-1:0] NB_ACQ  = NW'(ACQ_RISE - 1);

    logic              act;
    logic [PW-1:0]     ph;
    logic [NW-1:0]     nb;
    logic [WORD_W-1:0] wsh;

    // Marks the rising edge that opens the acquisition window.
    assign acq_mark = act && !sck && (ph == PH_END) && (nb == NB_ACQ);

    // Generates the clock phases, shifts the word out and the result in.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act  <= 1'b0;
            ph   <= '0;
            nb   <= '0;
            sck  <= 1'b0;
            sdi  <= 1'b0;
            wsh  <= '0;
            done <= 1'b0;
            data <= '0;
        end else begin
            done <= 1'b0;
            if (start) begin
                act <= 1'b1;
                ph  <= '0;
                nb  <= '0;
                sck <= 1'b0;
                sdi <= word[WORD_W-1];
                wsh <= {word[WORD_W-2:0], 1'b0};
            end else if (act) begin
                if (ph == PH_END) begin
                    ph <= '0;
                    if (!sck) begin
                        sck  <= 1'b1;
                        data <= {data[NBITS-2:0], sdo};
                    end else begin
                        sck <= 1'b0;
                        if (nb == NB_LAST) begin
                            act  <= 1'b0;
                            done <= 1'b1;
                        end else begin
                            nb  <= nb + 1'b1;
                            sdi <= wsh[WORD_W-1];
                            wsh <= {wsh[WORD_W-2:0], 1'b0};
                        end
                    end
                end else begin
                    ph <= ph + 1'b1;
                end
            end
        end
    end

    // R5: the outgoing bit must hold while the clock is high.
    a_r5_sdi_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (sck && $past(sck)) |-> $stable(sdi));
    // R5: the clock may change only when a full phase has passed.
    a_r5_phase_len: assert property (@(posedge clk) disable iff (!rst_n)
        (sck != $past(sck)) |-> ($past(ph) == PH_END));
    // R4: a readout ends only after the last pulse.
    a_r4_pulse_count: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(nb) == NB_LAST));

endmodule

// File: rtl/sarh_tag.sv
`timescale 1ns/1ps
// Module: setup pipeline and result formatting. It keeps the setup that
// the running conversion uses, together with the setup waiting to be sent.
// It labels each finished code with the setup that produced it and widens
// the code according to that setup's unipolar bit.
// Assumes: accept comes before the matching raw_done, one for one.
module sarh_tag #(
    parameter int                 RAW_W   = 12,
    parameter int                 RES_W   = 16,
    parameter sarh_pkg::sarh_cfg_t DEF_CFG = '0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 accept,
    input  sarh_pkg::sarh_cfg_t  req_cfg,
    input  logic                 raw_done,
    input  logic [RAW_W-1:0]     raw,
    output sarh_pkg::sarh_cfg_t  send_cfg,
    output logic                 res_valid,
    output logic [RES_W-1:0]     res_data,
    output sarh_pkg::sarh_cfg_t  res_cfg,
    output logic                 res_first
);
    sarh_pkg::sarh_cfg_t cur_cfg;
    logic                first_q;
    logic [RES_W-1:0]    ext;

    generate
        if (RES_W > RAW_W) begin : g_widen
            // Zero-fills unipolar codes and sign-fills bipolar codes.
            always_comb begin
                if (cur_cfg.uni)
                    ext = {{(RES_W-RAW_W){1'b0}}, raw};
                else
                    ext = {{(RES_W-RAW_W){raw[RAW_W-1]}}, raw};
            end
        end else begin : g_same
            // Passes the code through when no widening is needed.
            always_comb ext = raw[RES_W-1:0];
        end
    endgenerate

    // Keeps the two-stage setup pipeline and registers each result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_cfg   <= DEF_CFG;
            send_cfg  <= DEF_CFG;
            first_q   <= 1'b1;
            res_valid <= 1'b0;
            res_data  <= '0;
            res_cfg   <= DEF_CFG;
            res_first <= 1'b0;
        end else begin
            res_valid <= raw_done;
            if (accept)
                send_cfg <= req_cfg;
            if (raw_done) begin
                res_data  <= ext;
                res_cfg   <= cur_cfg;
                res_first <= first_q;
                cur_cfg   <= send_cfg;
                first_q   <= 1'b0;
            end
        end
    end

    // R9: once cleared, the first-result marker never comes back.
    a_r9_first_once: assert property (@(posedge clk) disable iff (!rst_n)
        !first_q |=> !first_q);
    // R8: the upper bits agree with the label's format.
    a_r8_widen: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (res_cfg.uni ? (res_data[RES_W-1:RAW_W] == '0)
                                   : (res_data[RES_W-1:RAW_W] == {(RES_W-RAW_W){res_data[RAW_W-1]}})));
    // R11: a result strobe lasts one cycle.
    a_r11_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);

endmodule

// File: rtl/sarh_ctrl.sv
`timescale 1ns/1ps
// Module: top-level sequencer for a serial 12-bit SAR converter. It turns
// every limit given in ns into a count of system cycles (rounded up),
// drives the start strobe, starts the serial engine and holds off the next
// request until the cycle, acquisition and tail limits are all met.
// Assumes: CLK_NS is the system clock period in whole nanoseconds.
module sarh_ctrl #(
    parameter int CLK_NS       = 8,
    parameter int CONV_NS      = 1600,
    parameter int CNV_HI_NS    = 20,
    parameter int SCK_PHASE_NS = 13,
    parameter int ACQ_NS       = 240,
    parameter int TAIL_NS      = 20,
    parameter int CYCLE_NS     = 2000,
    parameter int RAW_W        = 12,
    parameter int RES_W        = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_single,
    input  logic              req_odd,
    input  logic              req_uni,
    output logic              busy,
    output logic              adc_cnv,
    output logic              adc_sck,
    output logic              adc_sdi,
    input  logic              adc_sdo,
    output logic              res_valid,
    output logic [RES_W-1:0]  res_data,
    output logic              res_single,
    output logic              res_odd,
    output logic              res_uni,
    output logic              res_first
);
    import sarh_pkg::*;

    localparam int HI_NS  = (CONV_NS > CNV_HI_NS) ? CONV_NS : CNV_HI_NS;
    localparam int T_CONV = (HI_NS + CLK_NS - 1) / CLK_NS;
    localparam int T_HALF = (SCK_PHASE_NS + CLK_NS - 1) / CLK_NS;
    localparam int T_ACQ  = (ACQ_NS + CLK_NS - 1) / CLK_NS;
    localparam int T_TAIL = (TAIL_NS + CLK_NS - 1) / CLK_NS;
    localparam int T_CYC  = (CYCLE_NS + CLK_NS - 1) / CLK_NS;
    localparam int CW     = $clog2(T_CYC + T_CONV + 2) + 1;
    localparam logic [CW-1:0] C_CONV = CW'(T_CONV);
    localparam logic [CW-1:0] C_CYC  = CW'(T_CYC - 1);
    localparam logic [CW-1:0] C_ACQ  = CW'(T_ACQ - 1);
    localparam logic [CW-1:0] C_TAIL = CW'((T_TAIL > 1) ? T_TAIL - 1 : 0);
    localparam logic [CW-1:0] C_SAT  = '1;

    sarh_state_t       state;
    logic [CW-1:0]     cyc_cnt, acq_cnt, tail_cnt;
    logic              accept, link_start, acq_mark, link_done;
    logic [RAW_W-1:0]  raw;
    sarh_cfg_t         req_cfg, send_cfg, res_cfg;

    assign req_cfg    = '{single: req_single, odd: req_odd, uni: req_uni};
    assign accept     = (state == ST_IDLE) && req_valid;
    assign link_start = (state == ST_CONV) && (cyc_cnt >= C_CONV);
    assign busy       = (state != ST_IDLE);
    assign res_single = res_cfg.single;
    assign res_odd    = res_cfg.odd;
    assign res_uni    = res_cfg.uni;

    // Steps the sequence and drives the start strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            adc_cnv <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: if (accept) begin
                    state   <= ST_CONV;
                    adc_cnv <= 1'b1;
                end
                ST_CONV: if (link_start) begin
                    state   <= ST_READ;
                    adc_cnv <= 1'b0;
                end
                ST_READ: if (link_done) state <= ST_SETTLE;
                default: if (cyc_cnt >= C_CYC && acq_cnt >= C_ACQ && tail_cnt >= C_TAIL)
                    state <= ST_IDLE;
            endcase
        end
    end

    // Measures time since the start, since the acquisition mark and since the last fall.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyc_cnt  <= C_SAT;
            acq_cnt  <= C_SAT;
            tail_cnt <= C_SAT;
        end else begin
            cyc_cnt  <= accept    ? CW'(1) : (cyc_cnt  == C_SAT ? cyc_cnt  : cyc_cnt  + 1'b1);
            acq_cnt  <= acq_mark  ? CW'(1) : (acq_cnt  == C_SAT ? acq_cnt  : acq_cnt  + 1'b1);
            tail_cnt <= link_done ? CW'(1) : (tail_cnt == C_SAT ? tail_cnt : tail_cnt + 1'b1);
        end
    end

    sarh_link #(
        .NBITS(RAW_W), .WORD_W(WORD_W), .HALF(T_HALF), .ACQ_RISE(7)
    ) link_i (
        .clk(clk), .rst_n(rst_n), .start(link_start), .word(cfg_word(send_cfg)),
        .sdo(adc_sdo), .sck(adc_sck), .sdi(adc_sdi), .acq_mark(acq_mark),
        .done(link_done), .data(raw)
    );

    sarh_tag #(
        .RAW_W(RAW_W), .RES_W(RES_W), .DEF_CFG('0)
    ) tag_i (
        .clk(clk), .rst_n(rst_n), .accept(accept), .req_cfg(req_cfg),
        .raw_done(link_done), .raw(raw), .send_cfg(send_cfg),
        .res_valid(res_valid), .res_data(res_data), .res_cfg(res_cfg),
        .res_first(res_first)
    );

    // R1: the strobe rises only out of the idle state.
    a_r1_rise_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(adc_cnv) |-> $past(state == ST_IDLE));
    // R2: the strobe falls only after the conversion count.
    a_r2_conv_hold: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(adc_cnv) |-> ($past(cyc_cnt) >= C_CONV));
    // R6: start-to-start spacing and acquisition window.
    a_r6_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(adc_cnv) |-> ($past(cyc_cnt) >= C_CYC && $past(acq_cnt) >= C_ACQ));
    // R4: the serial clock is never high while the strobe is high.
    a_r4_sck_cnv: assert property (@(posedge clk) disable iff (!rst_n)
        adc_sck |-> !adc_cnv);
    // R11: the strobe is high only inside a busy sequence.
    a_r11_busy: assert property (@(posedge clk) disable iff (!rst_n)
        adc_cnv |-> busy);

endmodule

// File: tb/sarh_ctrl_tb_top.sv
`timescale 1ns/1ps
module sarh_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_single = 1'b0, req_odd = 1'b0, req_uni = 1'b0;
    logic        busy, adc_cnv, adc_sck, adc_sdi, res_valid;
    logic        res_single, res_odd, res_uni, res_first;
    logic [15:0] res_data;
    logic        sdo_m = 1'b0;

    int n_chk = 0, n_bad = 0, n_issued = 0, n_results = 0, n_rises = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    sarh_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_single(req_single),
        .req_odd(req_odd), .req_uni(req_uni), .busy(busy), .adc_cnv(adc_cnv),
        .adc_sck(adc_sck), .adc_sdi(adc_sdi), .adc_sdo(sdo_m), .res_valid(res_valid),
        .res_data(res_data), .res_single(res_single), .res_odd(res_odd),
        .res_uni(res_uni), .res_first(res_first)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] widen(input logic [11:0] c, input logic u);
        return u ? {4'h0, c} : {{4{c[11]}}, c};
    endfunction

    // ---------------- converter model ----------------
    logic [11:0] next_code = '0, cur_code = '0, shreg = '0;
    logic [2:0]  mcfg = 3'b000;      // {single, odd, uni}, power-on default
    bit          mfirst = 1, ever_rose = 0;
    logic [5:0]  latched = '0;
    int          sck_rises = 12;
    realtime     t_rise = 0, t_cfall = 0, t_sck_r = 0, t_sck_f = 0, t_rise7 = 0, t_lastfall = 0;
    logic [11:0] q_code[$];
    logic [2:0]  q_cfg[$];
    bit          q_first[$];
    logic [5:0]  q_word[$];

    always @(posedge adc_cnv) begin
        n_rises++;
        if (ever_rose) begin
            chk($realtime - t_rise >= 2000.0, "R6", "start spacing ns", longint'($realtime - t_rise), 2000);
            chk($realtime - t_rise7 >= 240.0, "R6", "acquisition ns", longint'($realtime - t_rise7), 240);
            chk($realtime - t_lastfall >= 20.0, "R6", "tail ns", longint'($realtime - t_lastfall), 20);
            chk(sck_rises == 12, "R4", "clock pulses per readout", sck_rises, 12);
        end
        ever_rose = 1;
        t_rise = $realtime;
        cur_code = next_code;
        q_code.push_back(next_code);
        q_cfg.push_back(mcfg);
        q_first.push_back(mfirst);
        mfirst = 0;
    end

    always @(negedge adc_cnv) begin
        if (ever_rose) begin
            chk($realtime - t_rise >= 1600.0, "R2", "strobe high ns", longint'($realtime - t_rise), 1600);
            t_cfall = $realtime;
            shreg = cur_code;
            sdo_m = shreg[11];
            sck_rises = 0;
            latched = '0;
        end
    end

    always @(posedge adc_sck) begin
        chk(!adc_cnv, "R4", "clock high while strobe low", adc_cnv, 0);
        if (sck_rises == 0)
            chk($realtime - t_cfall >= 13.0, "R5", "first low phase ns", longint'($realtime - t_cfall), 13);
        else begin
            chk($realtime - t_sck_f >= 13.0, "R5", "low phase ns", longint'($realtime - t_sck_f), 13);
            chk($realtime - t_sck_r >= 25.0, "R5", "period ns", longint'($realtime - t_sck_r), 25);
        end
        if (sck_rises < 6) latched = {latched[4:0], adc_sdi};
        sck_rises++;
        if (sck_rises == 6) begin
            if (q_word.size() > 0) begin
                logic [5:0] w;
                w = q_word.pop_front();
                chk(latched == w, "R3", "setup word sent", latched, w);
            end else
                chk(0, "R3", "setup word without request", latched, 0);
            mcfg = {latched[5], latched[4], latched[1]};
        end
        if (sck_rises == 7) t_rise7 = $realtime;
        t_sck_r = $realtime;
    end

    always @(negedge adc_sck) begin
        chk($realtime - t_sck_r >= 13.0, "R5", "high phase ns", longint'($realtime - t_sck_r), 13);
        shreg = {shreg[10:0], 1'b0};
        sdo_m = shreg[11];
        t_sck_f = $realtime;
        t_lastfall = $realtime;
    end

    // ---------------- result checker ----------------
    always @(negedge clk) begin
        if (rst_n && res_valid) begin
            n_results++;
            if (q_code.size() > 0) begin
                logic [11:0] c; logic [2:0] g; bit f;
                c = q_code.pop_front(); g = q_cfg.pop_front(); f = q_first.pop_front();
                chk(res_data == widen(c, g[0]), "R8", "widened data", res_data, widen(c, g[0]));
                chk({res_single, res_odd, res_uni} == g, "R7", "setup label",
                    {res_single, res_odd, res_uni}, g);
                chk(res_first == f, "R9", "first flag", res_first, f);
            end else
                chk(0, "R11", "result without conversion", 1, 0);
        end
    end

    // ---------------- driver ----------------
    task automatic issue(input bit s, input bit o, input bit u, input logic [11:0] code);
        do @(negedge clk); while (busy);
        next_code  = code;
        req_single = s; req_odd = o; req_uni = u;
        req_valid  = 1'b1;
        q_word.push_back({s, o, 2'b00, u, 1'b0});
        n_issued++;
        @(negedge clk);
        req_valid = 1'b0;
        chk(busy, "R11", "busy after accept", busy, 1);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        // R10: reset state
        chk(!adc_cnv && !adc_sck && !busy && !res_valid, "R10", "reset outputs",
            {adc_cnv, adc_sck, busy, res_valid}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!adc_cnv && !adc_sck && !busy && !res_valid, "R10", "after reset outputs",
            {adc_cnv, adc_sck, busy, res_valid}, 0);

        // Directed corners: R9 default label, R8 sign/zero fill, R7 pipelining
        issue(1'b0, 1'b0, 1'b0, 12'h800);
        issue(1'b1, 1'b1, 1'b1, 12'h7FF);
        issue(1'b1, 1'b0, 1'b0, 12'hFFF);
        issue(1'b0, 1'b1, 1'b1, 12'h800);
        issue(1'b0, 1'b0, 1'b1, 12'h000);

        // R1: request during a conversion must leave no trace
        issue(1'b1, 1'b0, 1'b1, 12'h123);
        repeat (40) @(negedge clk);
        req_single = 1'b0; req_odd = 1'b1; req_uni = 1'b0; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk(adc_cnv && busy, "R1", "strobe still high during ignored request",
            {adc_cnv, busy}, 3);
        repeat (300) @(negedge clk);
        chk(n_rises == n_issued, "R1", "start edges vs accepted requests", n_rises, n_issued);

        // Random stream
        for (int i = 0; i < 40; i++) begin
            logic [11:0] c;
            c = 12'($urandom);
            issue(1'($urandom), 1'($urandom), 1'($urandom), c);
        end
        do @(negedge clk); while (busy);
        repeat (5) @(negedge clk);
        chk(n_results == n_issued, "R11", "one result per conversion", n_results, n_issued);
        chk(n_rises == n_issued, "R1", "total start edges", n_rises, n_issued);
        finished = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule